// File: doc/BRIEF.md
# Alignment Marker Lock Tracker

This block watches the stream of 66-bit blocks arriving on one receive lane of a multi-lane link and decides whether that lane is locked to its alignment markers. It waits for a block flagged as a valid marker, records the lane number that marker carries, and then checks that a marker with the same lane number comes back at the expected spacing. While markers keep matching the lane stays locked. Repeated misses make it drop lock and ask the block aligner for a one-block slip.

During low-power signaling the transmitter sends rapid markers at a much shorter spacing. The marker decoder upstream reduces both kinds of marker to a valid flag and a lane number, so the tracker treats them alike. Only the spacing changes, and it follows the low-power flag. When rapid markers begin, the spacing counter restarts on the first one, so the lane stays locked across the change. When rapid markers end, the last one is compared with the low-power flag already low, and the tracker goes back to the long spacing. The 40G or 100G lane arrangement selects the rapid spacing. That selection is read while reset is asserted.

Top module: `am_lock_tracker`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, `lane_locked_o`, `slip_req_o` and `cnt_done_o` are all 0.
- R2: Without low power, a marker is expected after 16383 further valid blocks. `cnt_done_o` is 0 after 16382 of them and 1 after 16383. If the next valid block is a marker with the same lane number, `lane_locked_o` becomes 1.
- R3: With low power active, the expected spacing is 7 valid blocks when `mode_40g_i` was 0 at reset and 15 blocks when it was 1. `cnt_done_o` reports this.
- R4: A cycle with `blk_valid_i` at 0 does not advance the spacing count and does not change lock state.
- R5: Markers are compared by lane number only. A rapid marker, sent with `lpi_active_i` at 1, and a normal marker of the same lane match each other in both directions, so lock is kept.
- R6: While locked with the long spacing, the first valid block with `lpi_active_i` at 1 restarts the count with the short spacing, and lock is kept.
- R7: At an expected marker position, a block that is not a marker or that carries a different lane number adds one to an invalid count. A matching marker clears that count. The fourth consecutive miss clears `lane_locked_o` and raises `slip_req_o`.
- R8: In the short-spacing locked state, a valid marker with a different lane number arriving before the expected position clears lock and raises `slip_req_o` at once.
- R9: `slip_req_o` stays 1 until `slip_done_i` is seen. The tracker then returns to searching with all outputs 0 and needs a full new acquisition.
- R10: Before lock, a mismatch at the first expected position raises `slip_req_o` directly, and `lane_locked_o` never becomes 1.
- R11: Changes on `mode_40g_i` after reset has been released have no effect on the spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; mode is captured while low |
| mode_40g_i | input | 1 | 1 selects the 40G rapid spacing (15), 0 the 100G one (7) |
| blk_valid_i | input | 1 | A 66-bit block is present this cycle |
| mrk_valid_i | input | 1 | The present block is a valid normal or rapid marker |
| mrk_lane_i | input | LANE_W | Lane number decoded from the marker |
| lpi_active_i | input | 1 | Low-power receive flag, aligned to rapid markers |
| slip_done_i | input | 1 | The aligner has completed the requested slip |
| lane_locked_o | output | 1 | The lane is locked to its markers |
| slip_req_o | output | 1 | Request to slip block position |
| cnt_done_o | output | 1 | The spacing count has reached its terminal value |

## Verification
The hardest situation to reach is the hand-over between spacings while locked. The bench has to acquire lock on the full 16384-block period, then switch the low-power flag on a marker that falls at a non-expected position. After that it must see the short period and then return to the long one, all without a slip. The stimulus drives the long fillers with a loop and places a single flagged marker partway through a normal gap. It lowers the flag on the last rapid marker and then counts out a second long period before the final compare.

// File: rtl/amlt_pkg.sv
package amlt_pkg;

    typedef enum logic [2:0] {
        ST_SEARCH = 3'd0,
        ST_FIRST  = 3'd1,
        ST_TRACK  = 3'd2,
        ST_RAPID  = 3'd3,
        ST_SLIP   = 3'd4
    } lock_state_e;

endpackage

// File: rtl/amlt_tc_sel.sv
module amlt_tc_sel #(
    parameter int CW         = 14,
    parameter int NORM_TC    = 16383,
    parameter int RAP_TC_100 = 7,
    parameter int RAP_TC_40  = 15,
    parameter bit DEEP_SLEEP = 1'b1
) (
    input  logic          use_rapid_i,
    input  logic          sel_40g_i,
    output logic [CW-1:0] tc_o
);
    localparam logic [CW-1:0] LONG_TC = CW'(NORM_TC);

    logic [CW-1:0] short_tc;

    generate
        if (DEEP_SLEEP) begin : g_rapid
            assign short_tc = sel_40g_i ? CW'(RAP_TC_40) : CW'(RAP_TC_100);
        end else begin : g_norapid
            assign short_tc = LONG_TC;
        end
    endgenerate

    assign tc_o = use_rapid_i ? short_tc : LONG_TC;

    always_comb begin
        assert (tc_o != '0) else $error("assert_tc_nonzero_R3 violated");
    end
endmodule

// File: rtl/amlt_spacing_cnt.sv
module amlt_spacing_cnt #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          advance_i,
    input  logic [CW-1:0] tc_i,
    output logic          cnt_done_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    assign cnt_done_o = (cnt_q >= tc_i);

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (advance_i && !cnt_done_o) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !advance_i) |=> $stable(cnt_q));

    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !restart_i && !cnt_done_o) |=> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/am_lock_tracker.sv
module am_lock_tracker #(
    parameter int LANE_W     = 5,
    parameter int NORM_TC    = 16383,
    parameter int RAP_TC_100 = 7,
    parameter int RAP_TC_40  = 15,
    parameter bit DEEP_SLEEP = 1'b1,
    parameter int MISS_LIMIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_40g_i,
    input  logic              blk_valid_i,
    input  logic              mrk_valid_i,
    input  logic [LANE_W-1:0] mrk_lane_i,
    input  logic              lpi_active_i,
    input  logic              slip_done_i,
    output logic              lane_locked_o,
    output logic              slip_req_o,
    output logic              cnt_done_o
);
    import amlt_pkg::*;

    localparam int CW = $clog2(NORM_TC + 1);
    localparam int IW = $clog2(MISS_LIMIT + 1);
    localparam logic [IW-1:0] LAST_MISS = IW'(MISS_LIMIT - 1);

    typedef struct packed {
        lock_state_e       state;
        logic [LANE_W-1:0] first_lane;
        logic [IW-1:0]     miss_cnt;
    } trk_t;

    trk_t trk_d, trk_q;
    logic mode_q;

    logic          counting;
    logic          use_rapid;
    logic [CW-1:0] tc;
    logic          raw_done;
    logic          restart;
    logic          advance;
    logic          lane_match;
    lock_state_e   resume_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= mode_40g_i;
    end

    assign counting   = (trk_q.state == ST_FIRST) || (trk_q.state == ST_TRACK) ||
                        (trk_q.state == ST_RAPID);
    assign use_rapid  = (trk_q.state == ST_RAPID) ||
                        ((trk_q.state == ST_FIRST) && lpi_active_i);
    assign lane_match = mrk_valid_i && (mrk_lane_i == trk_q.first_lane);
    assign resume_state = lpi_active_i ? ST_RAPID : ST_TRACK;

    amlt_tc_sel #(
        .CW(CW), .NORM_TC(NORM_TC), .RAP_TC_100(RAP_TC_100),
        .RAP_TC_40(RAP_TC_40), .DEEP_SLEEP(DEEP_SLEEP)
    ) u_tc_sel (
        .use_rapid_i (use_rapid),
        .sel_40g_i   (mode_q),
        .tc_o        (tc)
    );

    amlt_spacing_cnt #(.CW(CW)) u_spacing (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart),
        .advance_i  (advance),
        .tc_i       (tc),
        .cnt_done_o (raw_done)
    );

    always_comb begin
        trk_d   = trk_q;
        restart = 1'b0;
        advance = 1'b0;
        unique case (trk_q.state)
            ST_SEARCH: begin
                if (blk_valid_i && mrk_valid_i) begin
                    trk_d.first_lane = mrk_lane_i;
                    trk_d.miss_cnt   = '0;
                    trk_d.state      = ST_FIRST;
                    restart          = 1'b1;
                end
            end
            ST_FIRST: begin
                if (blk_valid_i) begin
                    if (raw_done) begin
                        if (lane_match) begin
                            trk_d.state = resume_state;
                            restart     = 1'b1;
                        end else begin
                            trk_d.state = ST_SLIP;
                        end
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            ST_TRACK, ST_RAPID: begin
                if (blk_valid_i) begin
                    if ((trk_q.state == ST_TRACK) && lpi_active_i) begin
                        trk_d.state = ST_RAPID;
                        restart     = 1'b1;
                    end else if (raw_done) begin
                        if (lane_match) begin
                            trk_d.miss_cnt = '0;
                            trk_d.state    = resume_state;
                            restart        = 1'b1;
                        end else if (trk_q.miss_cnt == LAST_MISS) begin
                            trk_d.state = ST_SLIP;
                        end else begin
                            trk_d.miss_cnt = trk_q.miss_cnt + IW'(1);
                            trk_d.state    = resume_state;
                            restart        = 1'b1;
                        end
                    end else if ((trk_q.state == ST_RAPID) && mrk_valid_i && !lane_match) begin
                        trk_d.state = ST_SLIP;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            ST_SLIP: begin
                if (slip_done_i) begin
                    trk_d.state      = ST_SEARCH;
                    trk_d.miss_cnt   = '0;
                    trk_d.first_lane = '0;
                    restart          = 1'b1;
                end
            end
            default: begin
                trk_d.state = ST_SEARCH;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q.state      <= ST_SEARCH;
            trk_q.first_lane <= '0;
            trk_q.miss_cnt   <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign lane_locked_o = (trk_q.state == ST_TRACK) || (trk_q.state == ST_RAPID);
    assign slip_req_o    = (trk_q.state == ST_SLIP);
    assign cnt_done_o    = counting && raw_done;

    assert_slip_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_req_o && !slip_done_i) |=> slip_req_o);

    assert_slip_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_req_o && slip_done_i) |=> (!slip_req_o && !lane_locked_o));

    assert_lock_on_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_locked_o) |-> $past(blk_valid_i && mrk_valid_i && cnt_done_o));

    assert_loss_slips_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lane_locked_o) |-> slip_req_o);

    assert_idle_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_valid_i && !slip_req_o) |=> ($stable(lane_locked_o) && !slip_req_o));
endmodule

// File: tb/am_lock_tracker_tb.sv
module am_lock_tracker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       bv = 1'b0, mv = 1'b0, lpi = 1'b0, sd = 1'b0;
    logic [4:0] lane = '0;
    logic       locked, slip, done;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    am_lock_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .mode_40g_i(mode), .blk_valid_i(bv),
        .mrk_valid_i(mv), .mrk_lane_i(lane), .lpi_active_i(lpi),
        .slip_done_i(sd), .lane_locked_o(locked), .slip_req_o(slip),
        .cnt_done_o(done)
    );

    // vector: {bv, mv, lane[4:0], lpi, exp_locked, exp_slip, exp_done}
    localparam int NV = 19;
    localparam logic [10:0] VEC [NV] = '{
        {1'b1, 1'b1, 5'd3, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1},
        {1'b1, 1'b1, 5'd3, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1},
        {1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1},
        {1'b1, 1'b1, 5'd5, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: %s got %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic chk3(input string req, input logic el, input logic es, input logic ed);
        chk(req, "lane_locked", locked, el);
        chk(req, "slip_req", slip, es);
        chk(req, "cnt_done", done, ed);
    endtask

    task automatic blk(input logic b, input logic m, input logic [4:0] ln,
                       input logic lp, input logic s);
        @(negedge clk);
        bv = b; mv = m; lane = ln; lpi = lp; sd = s;
        @(posedge clk);
        #2;
    endtask

    task automatic fill(input int n, input logic lp);
        for (int i = 0; i < n; i++) blk(1'b1, 1'b0, 5'd0, lp, 1'b0);
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n = 1'b0; mode = m; bv = 0; mv = 0; lane = 0; lpi = 0; sd = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
    endtask

    // acquire lock on 100G rapid spacing, lane ln
    task automatic acquire_rapid(input logic [4:0] ln);
        blk(1'b1, 1'b1, ln, 1'b1, 1'b0);
        fill(7, 1'b1);
        blk(1'b1, 1'b1, ln, 1'b1, 1'b0);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete got 0 expected 1");
        summary();
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        #1;
        chk3("R1", 1'b0, 1'b0, 1'b0);
        do_reset(1'b0);
        chk3("R1", 1'b0, 1'b0, 1'b0);
        fill(3, 1'b0);
        chk3("R1", 1'b0, 1'b0, 1'b0);

        // R3 R4 R5 R7: vector table, 100G rapid spacing
        do_reset(1'b0);
        for (int v = 0; v < NV; v++) begin
            blk(VEC[v][10], VEC[v][9], VEC[v][8:4], VEC[v][3], 1'b0);
            chk3("R3/R4 table", VEC[v][2], VEC[v][1], VEC[v][0]);
        end

        // R7: misses, recovery, then four consecutive misses
        do_reset(1'b0);
        acquire_rapid(5'd9);
        chk("R7", "lock after acquire", locked, 1'b1);
        fill(7, 1'b1); blk(1'b1, 1'b1, 5'd4, 1'b1, 1'b0);
        chk("R7", "lock after miss 1", locked, 1'b1);
        fill(7, 1'b1); blk(1'b1, 1'b0, 5'd0, 1'b1, 1'b0);
        chk("R7", "lock after non-marker miss 2", locked, 1'b1);
        fill(7, 1'b1); blk(1'b1, 1'b1, 5'd4, 1'b1, 1'b0);
        chk("R7", "lock after miss 3", locked, 1'b1);
        fill(7, 1'b1); blk(1'b1, 1'b1, 5'd9, 1'b1, 1'b0);
        chk("R7", "lock after good marker", locked, 1'b1);
        for (int k = 0; k < 3; k++) begin
            fill(7, 1'b1); blk(1'b1, 1'b1, 5'd1, 1'b1, 1'b0);
            chk("R7", "lock during second run of misses", locked, 1'b1);
        end
        fill(7, 1'b1); blk(1'b1, 1'b1, 5'd1, 1'b1, 1'b0);
        chk("R7", "lock after fourth miss", locked, 1'b0);
        chk("R7", "slip after fourth miss", slip, 1'b1);

        // R9: slip handshake
        blk(1'b1, 1'b1, 5'd9, 1'b1, 1'b0);
        blk(1'b1, 1'b0, 5'd0, 1'b1, 1'b0);
        chk("R9", "slip held without done", slip, 1'b1);
        blk(1'b1, 1'b0, 5'd0, 1'b1, 1'b1);
        chk3("R9", 1'b0, 1'b0, 1'b0);
        blk(1'b1, 1'b1, 5'd9, 1'b1, 1'b0);
        fill(7, 1'b1);
        chk("R9", "relock needs full spacing", locked, 1'b0);
        blk(1'b1, 1'b1, 5'd9, 1'b1, 1'b0);
        chk("R9", "relock after fresh acquisition", locked, 1'b1);

        // R10: first compare mismatch
        do_reset(1'b0);
        blk(1'b1, 1'b1, 5'd3, 1'b1, 1'b0);
        fill(7, 1'b1);
        blk(1'b1, 1'b1, 5'd4, 1'b1, 1'b0);
        chk("R10", "slip on first mismatch", slip, 1'b1);
        chk("R10", "never locked", locked, 1'b0);

        // R8: mid-gap foreign marker while rapid-locked
        do_reset(1'b0);
        acquire_rapid(5'd6);
        fill(3, 1'b1);
        blk(1'b1, 1'b1, 5'd6, 1'b1, 1'b0);
        chk("R8", "same-lane mid-gap keeps lock", locked, 1'b1);
        blk(1'b1, 1'b1, 5'd7, 1'b1, 1'b0);
        chk("R8", "lock after foreign marker", locked, 1'b0);
        chk("R8", "slip after foreign marker", slip, 1'b1);

        // R3 R11: 40G spacing captured at reset
        do_reset(1'b1);
        blk(1'b1, 1'b1, 5'd2, 1'b1, 1'b0);
        fill(14, 1'b1);
        chk("R3", "40G done after 14", done, 1'b0);
        fill(1, 1'b1);
        chk("R3", "40G done after 15", done, 1'b1);
        blk(1'b1, 1'b1, 5'd2, 1'b1, 1'b0);
        chk("R3", "40G lock", locked, 1'b1);
        mode = 1'b0;
        fill(7, 1'b1);
        chk("R11", "mode change after reset ignored", done, 1'b0);
        fill(8, 1'b1);
        chk("R11", "40G spacing kept", done, 1'b1);

        // R2 R5 R6: long spacing, rapid entry, return to long
        do_reset(1'b0);
        blk(1'b1, 1'b1, 5'd2, 1'b0, 1'b0);
        fill(16382, 1'b0);
        chk("R2", "done after 16382", done, 1'b0);
        fill(1, 1'b0);
        chk("R2", "done after 16383", done, 1'b1);
        chk("R2", "not yet locked", locked, 1'b0);
        blk(1'b1, 1'b1, 5'd2, 1'b0, 1'b0);
        chk("R2", "locked on long spacing", locked, 1'b1);
        fill(100, 1'b0);
        blk(1'b1, 1'b1, 5'd2, 1'b1, 1'b0);
        chk("R6", "lock kept on first rapid marker", locked, 1'b1);
        fill(6, 1'b1);
        chk("R6", "short spacing not done at 6", done, 1'b0);
        fill(1, 1'b1);
        chk("R6", "short spacing done at 7", done, 1'b1);
        blk(1'b1, 1'b1, 5'd2, 1'b1, 1'b0);
        chk("R5", "rapid marker matches normal lane", locked, 1'b1);
        fill(7, 1'b1);
        blk(1'b1, 1'b1, 5'd2, 1'b0, 1'b0);
        chk("R5", "last rapid marker keeps lock", locked, 1'b1);
        fill(7, 1'b0);
        chk("R5", "long spacing restored", done, 1'b0);
        fill(16376, 1'b0);
        chk("R5", "long spacing done", done, 1'b1);
        blk(1'b1, 1'b1, 5'd2, 1'b0, 1'b0);
        chk("R5", "normal marker after rapid keeps lock", locked, 1'b1);
        chk("R5", "no slip across changeover", slip, 1'b0);

        summary();
    end
endmodule